// File: doc/BRIEF.md
# Throttled Cycle-Steal DMA Sequencer

This block moves a programmed number of transfer units from a source region to a destination region over a bus it shares with another master. It moves one unit at a time. For each unit it raises a bus request, waits for the grant, and then performs a read at the source address followed by a write at the destination address. Once the unit is complete it hands the bus back to the other master.

A 16-byte unit is moved as four longword read/write pairs, and the bus is kept for all four pairs. Both addresses advance by the size of each beat, and the unit count drops by one per unit. A done flag rises when the count reaches zero.

The mode setting controls how soon the block may take the bus again. In normal mode the block requests the bus again one cycle after releasing it. In the two intermittent modes it must first sit idle for 16 or 64 clocks. This caps the share of bus time that the transfer can take. The transfer request input is an active-low level. A request that shows up during the idle gap is remembered and served when the gap ends.

Top module: `dma_steal_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, bus_req, rd_stb, wr_stb and done are 0 and remaining is 0.
- R2: After a start, no bus request is raised while xfer_req_n is high. The programmed count is kept unchanged during that time.
- R3: Once bus_req is high it stays high until bus_gnt is seen. rd_stb and wr_stb are high only in cycles where bus_gnt is high.
- R4: Each beat is a single-cycle rd_stb with src_addr as the read address, then a wr_stb with dst_addr as the write address. wr_data equals the rd_data captured during that beat's read.
- R5: unit_sel encodes the unit size: 0 = byte, 1 = word (2), 2 = longword (4), 3 = 16 bytes. After each beat both addresses advance by the beat size. A 16-byte unit is four longword beats, and bus_req stays high across all four.
- R6: After every completed unit, bus_req drops for at least one cycle, even when the request input is still low.
- R7: mode_sel = 0 (normal) with the request held low: bus_req is low for exactly 1 cycle between units.
- R8: mode_sel = 1 gives a 16-cycle idle gap, and mode_sel = 2 or 3 gives a 64-cycle gap. With the request held low, bus_req is low for exactly that many cycles between units.
- R9: In an intermittent mode, a request that is low at any point during the gap is held pending. The next unit then starts when the gap ends, even if xfer_req_n has returned high.
- R10: remaining drops by one per completed unit. When it reaches zero, done goes high and no further bus request is made. done clears on the next accepted start.
- R11: start is accepted only when idle. A start with cfg_count = 0 sets done in the next cycle and creates no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load the configuration and arm the sequencer (accepted only when idle) |
| cfg_src | input | AW | Starting source address |
| cfg_dst | input | AW | Starting destination address |
| cfg_count | input | CW | Number of units to move |
| unit_sel | input | 2 | Unit size code |
| mode_sel | input | 2 | 0 normal, 1 gap of 16, 2/3 gap of 64 |
| xfer_req_n | input | 1 | Active-low transfer request level |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| rd_stb | output | 1 | Source read strobe |
| wr_stb | output | 1 | Destination write strobe |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| beat_size | output | 2 | Size code of the current beat (never 3) |
| rd_data | input | DW | Read data, sampled with rd_stb |
| wr_data | output | DW | Write data |
| remaining | output | CW | Units still to move |
| done | output | 1 | Count has reached zero |

## Verification
The sequencer runs with the request held low under each of the three modes. This makes the idle run between units measurable, and the run separates the one-cycle normal gap from the 16- and 64-cycle intermittent gaps. Byte, word, longword and 16-byte units each run with their own address steps and bus grant latencies. This exposes errors in beat splitting, in address stepping and in holding the bus across a 16-byte unit. Further runs check other request patterns: a request kept high after start must raise no bus request, a short pulse inside an intermittent gap must still start the next unit, and a zero count must finish at once with no bus activity.

// File: rtl/dma_steal_pkg.sv
// Shared types for the cycle-steal DMA sequencer.
// Assumes: unit codes are fixed by the configuration interface.
package dma_steal_pkg;

    typedef enum logic [1:0] {
        UNIT_BYTE = 2'd0,
        UNIT_WORD = 2'd1,
        UNIT_LONG = 2'd2,
        UNIT_QUAD = 2'd3
    } unit_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_GAP
    } state_e;

    // Bytes moved by one beat of the given unit code; 16-byte units use longword beats.
    function automatic logic [2:0] beat_bytes(unit_e u);
        case (u)
            UNIT_BYTE: beat_bytes = 3'd1;
            UNIT_WORD: beat_bytes = 3'd2;
            default:   beat_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_gen.sv
// Source/destination address and unit counter.
// Loads on 'load'; advances both addresses by 'beat_inc' per finished beat
// and decrements the unit count per finished unit. Assumes the caller never
// asserts unit_done when the count is zero.
module dma_addr_gen #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic          beat_done,
    input  logic [2:0]    beat_inc,
    input  logic          unit_done,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] count
);

    // Address and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src   <= '0;
            dst   <= '0;
            count <= '0;
        end else if (load) begin
            src   <= src_in;
            dst   <= dst_in;
            count <= cnt_in;
        end else begin
            if (beat_done) begin
                src <= src + AW'(beat_inc);
                dst <= dst + AW'(beat_inc);
            end
            if (unit_done) begin
                count <= count - CW'(1);
            end
        end
    end

endmodule

// File: rtl/dma_gap_timer.sv
// Hold-off timer for intermittent mode.
// On 'load' it is set to SHORT-1 or LONG-1 cycles; 'expired' is high once it
// has counted down to zero, so a state that waits for it lasts SHORT or LONG cycles.
module dma_gap_timer #(
    parameter int SHORT = 16,
    parameter int LONG  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_long,
    output logic expired
);

    localparam int W = (LONG > 2) ? $clog2(LONG) : 1;
    localparam logic [W-1:0] SHORT_LD = W'(SHORT - 1);
    localparam logic [W-1:0] LONG_LD  = W'(LONG - 1);

    logic [W-1:0] cnt_q;

    // Down-counter, reloaded at each bus release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= sel_long ? LONG_LD : SHORT_LD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dma_steal_seq.sv
// Single-channel cycle-steal DMA sequencer (top).
// One unit per bus tenure: request, wait for grant, read/write beats, release.
// Normal mode re-arms one cycle after release; intermittent modes idle for
// GAP_SHORT or GAP_LONG cycles first. Assumes the arbiter keeps bus_gnt high
// until bus_req drops; strobes are gated by bus_gnt regardless.
module dma_steal_seq
    import dma_steal_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CW        = 16,
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    unit_sel,
    input  logic [1:0]    mode_sel,
    input  logic          xfer_req_n,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          rd_stb,
    output logic          wr_stb,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [1:0]    beat_size,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] wr_data,
    output logic [CW-1:0] remaining,
    output logic          done
);

    localparam int BEATS_QUAD = 4;
    localparam int BW         = $clog2(BEATS_QUAD);

    state_e        state_q;
    unit_e         unit_q;
    logic [1:0]    mode_q;
    logic [BW-1:0] beat_q;
    logic          pend_q;
    logic          done_q;
    logic [DW-1:0] data_q;

    logic accept;
    logic wr_fire;
    logic last_beat;
    logic unit_end;
    logic final_unit;
    logic gap_load;
    logic gap_expired;
    logic intermittent;
    logic req_seen;

    assign accept       = start && (state_q == ST_IDLE);
    assign rd_stb       = (state_q == ST_RD) && bus_gnt;
    assign wr_stb       = (state_q == ST_WR) && bus_gnt;
    assign wr_fire      = wr_stb;
    assign last_beat    = (unit_q != UNIT_QUAD) || (beat_q == BW'(BEATS_QUAD - 1));
    assign unit_end     = wr_fire && last_beat;
    assign final_unit   = (remaining == CW'(1));
    assign intermittent = (mode_q != 2'd0);
    assign gap_load     = unit_end && !final_unit && intermittent;
    assign req_seen     = pend_q || !xfer_req_n;

    // Bus request covers waiting for grant and the whole unit.
    assign bus_req   = (state_q == ST_REQ) || (state_q == ST_RD) || (state_q == ST_WR);
    assign beat_size = (unit_q == UNIT_QUAD) ? UNIT_LONG : unit_q;
    assign wr_data   = data_q;
    assign done      = done_q;

    dma_addr_gen #(
        .AW (AW),
        .CW (CW)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .src_in    (cfg_src),
        .dst_in    (cfg_dst),
        .cnt_in    (cfg_count),
        .beat_done (wr_fire),
        .beat_inc  (beat_bytes(unit_q)),
        .unit_done (unit_end),
        .src       (src_addr),
        .dst       (dst_addr),
        .count     (remaining)
    );

    dma_gap_timer #(
        .SHORT (GAP_SHORT),
        .LONG  (GAP_LONG)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .sel_long (mode_q[1]),
        .expired  (gap_expired)
    );

    // Sequencer state, configuration latches, beat index, pending flag, done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            unit_q  <= UNIT_BYTE;
            mode_q  <= 2'd0;
            beat_q  <= '0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        unit_q <= unit_e'(unit_sel);
                        mode_q <= mode_sel;
                        beat_q <= '0;
                        pend_q <= 1'b0;
                        if (cfg_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q  <= 1'b0;
                            state_q <= ST_ARM;
                        end
                    end
                end
                ST_ARM: begin
                    if (!xfer_req_n) state_q <= ST_REQ;
                end
                ST_REQ: begin
                    if (bus_gnt) state_q <= ST_RD;
                end
                ST_RD: begin
                    if (bus_gnt) state_q <= ST_WR;
                end
                ST_WR: begin
                    if (wr_fire) begin
                        if (!last_beat) begin
                            beat_q  <= beat_q + BW'(1);
                            state_q <= ST_RD;
                        end else begin
                            beat_q <= '0;
                            if (final_unit) begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end else if (intermittent) begin
                                pend_q  <= 1'b0;
                                state_q <= ST_GAP;
                            end else begin
                                state_q <= ST_ARM;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_expired) begin
                        pend_q  <= 1'b0;
                        state_q <= req_seen ? ST_REQ : ST_ARM;
                    end else begin
                        pend_q <= req_seen;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Read data holding register feeding the write beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_stb) begin
            data_q <= rd_data;
        end
    end

endmodule

// File: rtl/dma_steal_chk.sv
// Protocol checker for dma_steal_seq, attached by bind.
// Assumes synchronous active-low reset held for at least two clocks.
module dma_steal_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          rd_stb,
    input logic          wr_stb,
    input logic          done,
    input logic [CW-1:0] remaining
);

    logic rd_open;

    // Tracks a read beat that still awaits its write.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_open <= 1'b0;
        else if (rd_stb) rd_open <= 1'b1;
        else if (wr_stb) rd_open <= 1'b0;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (bus_req && !bus_gnt) |=> bus_req); // R3
    AST_STB_GRANTED: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb || wr_stb) |-> bus_gnt); // R3
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rd_stb |=> !rd_stb); // R4
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> rd_open); // R4
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!bus_req && !rd_stb && !wr_stb)); // R10
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!$past(start) && remaining != $past(remaining)) |-> remaining == $past(remaining) - CW'(1)); // R10

endmodule

bind dma_steal_seq dma_steal_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .done      (done),
    .remaining (remaining)
);

// File: tb/test_dma_steal_seq.sv
// Directed bench for dma_steal_seq: one task per scenario, each checking itself.
module test_dma_steal_seq;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam logic [31:0] DKEY = 32'hA5A5_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    unit_sel = 2'd0;
    logic [1:0]    mode_sel = 2'd0;
    logic          xfer_req_n = 1'b1;
    logic          bus_gnt = 1'b0;
    logic          bus_req, rd_stb, wr_stb, done;
    logic [AW-1:0] src_addr, dst_addr;
    logic [1:0]    beat_size;
    logic [DW-1:0] rd_data, wr_data;
    logic [CW-1:0] remaining;

    int checks = 0;
    int errors = 0;

    // Grant model and monitor state.
    int gnt_lat = 0;
    int step = 1;
    logic [AW-1:0] exp_src, exp_dst;
    logic [DW-1:0] exp_data;
    int n_wr, n_rises, low_run, gap_min, gap_max;
    logic prev_req, prev_gnt;

    always #10 clk = ~clk;

    assign rd_data = src_addr ^ DKEY;

    dma_steal_seq #(.AW(AW), .DW(DW), .CW(CW)) i_dma_steal_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_count(cfg_count), .unit_sel(unit_sel), .mode_sel(mode_sel),
        .xfer_req_n(xfer_req_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .src_addr(src_addr), .dst_addr(dst_addr),
        .beat_size(beat_size), .rd_data(rd_data), .wr_data(wr_data),
        .remaining(remaining), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Arbiter: grants after gnt_lat cycles of request, drops with the request.
    task automatic grant_model();
        int w = 0;
        forever begin
            @(negedge clk);
            if (bus_req) begin
                if (w >= gnt_lat) bus_gnt = 1'b1;
                else w++;
            end else begin
                bus_gnt = 1'b0;
                w = 0;
            end
        end
    endtask

    // Per-cycle monitor, sampled after the grant model has settled.
    task automatic monitor();
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (prev_req && !prev_gnt)
                    check(bus_req == 1'b1, "R3", "request dropped before grant", bus_req, 1);
                if (rd_stb) begin
                    check(bus_gnt == 1'b1, "R3", "read strobe without grant", bus_gnt, 1);
                    check(src_addr == exp_src, "R5", "read address", src_addr, exp_src);
                    exp_data = src_addr ^ DKEY;
                    exp_src  = exp_src + AW'(step);
                end
                if (wr_stb) begin
                    check(bus_gnt == 1'b1, "R3", "write strobe without grant", bus_gnt, 1);
                    check(dst_addr == exp_dst, "R5", "write address", dst_addr, exp_dst);
                    check(wr_data == exp_data, "R4", "write data", wr_data, exp_data);
                    exp_dst = exp_dst + AW'(step);
                    n_wr++;
                end
                if (bus_req && !prev_req) begin
                    n_rises++;
                    if (n_wr > 0) begin
                        if (low_run < gap_min) gap_min = low_run;
                        if (low_run > gap_max) gap_max = low_run;
                    end
                end
                if (!bus_req) low_run++;
                else low_run = 0;
                prev_req = bus_req;
                prev_gnt = bus_gnt;
            end
        end
    endtask

    task automatic arm(input logic [AW-1:0] s, input logic [AW-1:0] d, input int cnt,
                       input int unit, input int mode, input int lat);
        gnt_lat  = lat;
        step     = (unit == 0) ? 1 : (unit == 1) ? 2 : 4;
        exp_src  = s;
        exp_dst  = d;
        n_wr     = 0;
        n_rises  = 0;
        low_run  = 0;
        gap_min  = 1000000;
        gap_max  = 0;
        @(negedge clk);
        cfg_src   = s;
        cfg_dst   = d;
        cfg_count = CW'(cnt);
        unit_sel  = 2'(unit);
        mode_sel  = 2'(mode);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, req, "done after transfer", done, 1);
        check(remaining == '0, req, "remaining at end", remaining, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(bus_req == 1'b0 && rd_stb == 1'b0 && wr_stb == 1'b0, "R1", "strobes in reset",
              {bus_req, rd_stb, wr_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(remaining == '0, "R1", "remaining after reset", remaining, 0);
    endtask

    task automatic t_no_request();
        int seen = 0;
        xfer_req_n = 1'b1;
        arm(32'h100, 32'h800, 2, 2, 0, 1);
        repeat (30) begin
            @(negedge clk);
            #1;
            if (bus_req) seen++;
        end
        check(seen == 0, "R2", "bus requests while request input high", seen, 0);
        check(remaining == CW'(2), "R2", "count kept while waiting", remaining, 2);
        xfer_req_n = 1'b0;
        wait_done("R2");
        check(n_wr == 2, "R2", "units after request", n_wr, 2);
        xfer_req_n = 1'b1;
    endtask

    task automatic t_normal_byte();
        xfer_req_n = 1'b0;
        arm(32'h1000, 32'h2003, 3, 0, 0, 3);
        wait_done("R10");
        check(n_rises == 3, "R6", "bus tenures for 3 units", n_rises, 3);
        check(gap_min == 1 && gap_max == 1, "R7", "normal gap", gap_max, 1);
        check(src_addr == 32'h1003, "R5", "final byte source", src_addr, 32'h1003);
        xfer_req_n = 1'b1;
    endtask

    task automatic t_word_gap16();
        xfer_req_n = 1'b0;
        arm(32'h40, 32'h90, 3, 1, 1, 0);
        wait_done("R8");
        check(gap_min == 16 && gap_max == 16, "R8", "16-cycle gap", gap_max, 16);
        check(n_wr == 3, "R5", "word beats", n_wr, 3);
        check(dst_addr == 32'h96, "R5", "final word dest", dst_addr, 32'h96);
        xfer_req_n = 1'b1;
    endtask

    task automatic t_quad_gap64();
        xfer_req_n = 1'b0;
        arm(32'h3000, 32'h5000, 2, 3, 2, 2);
        wait_done("R8");
        check(n_wr == 8, "R5", "longword beats for two 16-byte units", n_wr, 8);
        check(n_rises == 2, "R5", "one tenure per 16-byte unit", n_rises, 2);
        check(gap_min == 64 && gap_max == 64, "R8", "64-cycle gap", gap_max, 64);
        check(src_addr == 32'h3020, "R5", "final 16-byte source", src_addr, 32'h3020);
        xfer_req_n = 1'b1;
    endtask

    task automatic t_pending();
        int n = 0;
        xfer_req_n = 1'b0;
        arm(32'h200, 32'h400, 2, 2, 1, 0);
        while (n_wr < 1 && n < 200) begin
            @(negedge clk);
            n++;
        end
        xfer_req_n = 1'b1;
        repeat (5) @(negedge clk);
        xfer_req_n = 1'b0;
        @(negedge clk);
        xfer_req_n = 1'b1;
        wait_done("R9");
        check(n_wr == 2, "R9", "pending request served", n_wr, 2);
        check(gap_max == 16, "R9", "pending served at gap end", gap_max, 16);
    endtask

    task automatic t_zero_count();
        int seen = 0;
        xfer_req_n = 1'b0;
        arm(32'h0, 32'h0, 0, 0, 0, 0);
        #1;
        check(done == 1'b1, "R11", "done for zero count", done, 1);
        repeat (10) begin
            @(negedge clk);
            #1;
            if (bus_req) seen++;
        end
        check(seen == 0, "R11", "bus activity for zero count", seen, 0);
        xfer_req_n = 1'b1;
    endtask

    task automatic t_done_clears();
        arm(32'h10, 32'h20, 1, 0, 0, 0);
        #1;
        check(done == 1'b0, "R10", "done cleared by start", done, 0);
        xfer_req_n = 1'b0;
        wait_done("R10");
        xfer_req_n = 1'b1;
    endtask

    initial begin
        prev_req = 1'b0;
        prev_gnt = 1'b0;
        fork
            grant_model();
            monitor();
        join_none
        t_reset();
        t_no_request();
        t_normal_byte();
        t_word_gap16();
        t_quad_gap64();
        t_pending();
        t_zero_count();
        t_done_clears();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule